// File: doc/BRIEF.md
# Tournament Branch Direction and Target Predictor

This block guesses, for the instruction address being fetched, whether a branch there will be taken. It also gives the next address to fetch. It keeps two direction guessers side by side. The first is a table of 2-bit counters selected by the low PC bits, which suits branches that nearly always go the same way. The second is a table of 2-bit counters selected by a shift register that holds the most recent resolved outcomes, which suits branches whose outcome follows the path taken by earlier branches. A third table of 2-bit counters, also selected by PC bits, records for each branch which of the two guessers has been more reliable, and its choice becomes the final direction. A small direct-mapped target table holds the destinations of branches that were seen taken. When the final guess is taken and the target table holds an entry for the fetch address, the next fetch address is the stored destination. In every other case it is the fetch address plus four.

The fetch side is purely combinational. The resolve port reports the real outcome of a branch, and the tables are updated at the next clock edge. A resolve reads the global table through the history as it stands before that edge, so the design assumes each branch resolves before the next resolve moves the history on. Squashing wrong-path work and fetching instructions are left to the surrounding pipeline.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every counter in all three tables holds 01, the history is all zeros and no target entry is valid. So for any fetch address: both component guesses are not-taken, the chooser picks the PC-indexed component, `btb_hit` is 0 and `next_pc` is `fetch_pc`+4.
- R2: The PC-indexed counter is selected by `pc[BIM_BITS+1:2]`. It is a 2-bit saturating counter: it steps up on a taken resolve, steps down on a not-taken one, stops at 11 and 00, and `bim_taken` is its bit 1.
- R3: The history-indexed counter is selected by the full history value. It follows the same saturating rule, and `gbl_taken` is its bit 1.
- R4: The chooser counter is selected by `pc[CHO_BITS+1:2]`. Values 10 and 11 set `pick_global` and select `gbl_taken`. Values 00 and 01 select `bim_taken`. `pred_taken` equals the selected guess.
- R5: On a resolve, the chooser counter changes only when the two component guesses for that branch differ. It steps up (saturating) when the history component was right and steps down when the PC component was right.
- R6: Every resolve updates both component counters. The history then shifts left by one, with the outcome (1 = taken) entering bit 0.
- R7: A taken resolve writes the target entry selected by `pc[TGT_BITS+1:2]` with the remaining upper PC bits as tag, together with the target, and marks it valid. `btb_hit` is 1 when the selected entry is valid and its tag matches `fetch_pc`.
- R8: `next_pc` is the stored target when `btb_hit` and `pred_taken` are both 1, and `fetch_pc`+4 otherwise.
- R9: While `res_valid` is 0, the resolve inputs change no table and leave the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched |
| bim_taken | output | 1 | PC-indexed component guess |
| gbl_taken | output | 1 | History-indexed component guess |
| pick_global | output | 1 | Chooser selects the history component |
| pred_taken | output | 1 | Final direction guess |
| btb_hit | output | 1 | Target table holds an entry for `fetch_pc` |
| next_pc | output | PC_W | Next fetch address |
| res_valid | input | 1 | A branch outcome is being reported |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Outcome of the resolved branch, 1 = taken |
| res_target | input | PC_W | Destination of the resolved branch |

## Verification
The directed sequences cover several kinds of branch. A branch that is always taken moves the PC counter to saturation and shows that it stops there. A branch that is never taken checks the lower bound. A branch with a 1,1,1,0 pattern, and another that copies the previous outcome, make the two components disagree, so the chooser is seen to move one way and then the other. Two addresses that share table indices but differ in upper bits separate index aliasing in the counters from tag rejection in the target table. In idle cycles with `res_valid` low, random resolve inputs are shown to change nothing. A long mixed run compares every output against a behavioural model on every cycle.

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
  parameter int PC_W      = 32,
  parameter int BIM_BITS  = 6,
  parameter int HIST_BITS = 6,
  parameter int CHO_BITS  = 6,
  parameter int TGT_BITS  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            bim_taken,
  output logic            gbl_taken,
  output logic            pick_global,
  output logic            pred_taken,
  output logic            btb_hit,
  output logic [PC_W-1:0] next_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target
);
  localparam int BIM_N = 1 << BIM_BITS;
  localparam int GBL_N = 1 << HIST_BITS;
  localparam int CHO_N = 1 << CHO_BITS;
  localparam int TGT_N = 1 << TGT_BITS;
  localparam int TAG_W = PC_W - 2 - TGT_BITS;

  logic [1:0]       bim [BIM_N];
  logic [1:0]       gbl [GBL_N];
  logic [1:0]       cho [CHO_N];
  logic             tv  [TGT_N];
  logic [TAG_W-1:0] tt  [TGT_N];
  logic [PC_W-1:0]  td  [TGT_N];
  logic [HIST_BITS-1:0] ghr;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  wire [BIM_BITS-1:0] f_bi  = fetch_pc[BIM_BITS+1:2];
  wire [CHO_BITS-1:0] f_ci  = fetch_pc[CHO_BITS+1:2];
  wire [TGT_BITS-1:0] f_ti  = fetch_pc[TGT_BITS+1:2];
  wire [TAG_W-1:0]    f_tag = fetch_pc[PC_W-1:TGT_BITS+2];

  assign bim_taken   = bim[f_bi][1];
  assign gbl_taken   = gbl[ghr][1];
  assign pick_global = cho[f_ci][1];
  assign pred_taken  = pick_global ? gbl_taken : bim_taken;
  assign btb_hit     = tv[f_ti] && (tt[f_ti] == f_tag);
  assign next_pc     = (btb_hit && pred_taken) ? td[f_ti] : fetch_pc + PC_W'(4);

  wire [BIM_BITS-1:0] r_bi  = res_pc[BIM_BITS+1:2];
  wire [CHO_BITS-1:0] r_ci  = res_pc[CHO_BITS+1:2];
  wire [TGT_BITS-1:0] r_ti  = res_pc[TGT_BITS+1:2];
  wire [1:0]          r_bc  = bim[r_bi];
  wire [1:0]          r_gc  = gbl[ghr];
  wire [1:0]          r_cc  = cho[r_ci];
  wire                split = r_bc[1] ^ r_gc[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BIM_N; i++) bim[i] <= 2'b01;
      for (int i = 0; i < GBL_N; i++) gbl[i] <= 2'b01;
      for (int i = 0; i < CHO_N; i++) cho[i] <= 2'b01;
      for (int i = 0; i < TGT_N; i++) begin
        tv[i] <= 1'b0;
        tt[i] <= '0;
        td[i] <= '0;
      end
      ghr <= '0;
    end else if (res_valid) begin
      bim[r_bi] <= sat(r_bc, res_taken);
      gbl[ghr]  <= sat(r_gc, res_taken);
      if (split) cho[r_ci] <= sat(r_cc, r_gc[1] == res_taken);
      ghr <= {ghr[HIST_BITS-2:0], res_taken};
      if (res_taken) begin
        tv[r_ti] <= 1'b1;
        tt[r_ti] <= res_pc[PC_W-1:TGT_BITS+2];
        td[r_ti] <= res_target;
      end
    end
  end
endmodule

module tourney_predictor_chk #(
  parameter int PC_W      = 32,
  parameter int HIST_BITS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PC_W-1:0]      fetch_pc,
  input logic                 bim_taken,
  input logic                 gbl_taken,
  input logic                 pred_taken,
  input logic                 btb_hit,
  input logic                 res_valid,
  input logic [PC_W-1:0]      res_pc,
  input logic                 res_taken,
  input logic [HIST_BITS-1:0] ghr
);
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> ghr[0] == $past(res_taken)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !res_valid |=> $stable(ghr)); // R9
  AST_AGREE_PASS: assert property (@(posedge clk) disable iff (!rst_n) (bim_taken == gbl_taken) |-> pred_taken == bim_taken); // R4
  AST_FILL_HIT: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_taken) |=> (fetch_pc != $past(res_pc)) || btb_hit); // R7
endmodule

bind tourney_predictor tourney_predictor_chk #(.PC_W(PC_W), .HIST_BITS(HIST_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .bim_taken(bim_taken),
  .gbl_taken(gbl_taken), .pred_taken(pred_taken), .btb_hit(btb_hit),
  .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken), .ghr(ghr)
);

// File: tb/tourney_predictor_test.sv
`timescale 1ns/1ps
module tourney_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0, res_pc = '0, res_target = '0;
  logic        res_valid = 1'b0, res_taken = 1'b0;
  logic        bim_taken, gbl_taken, pick_global, pred_taken, btb_hit;
  logic [31:0] next_pc;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tourney_predictor uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .bim_taken(bim_taken),
    .gbl_taken(gbl_taken), .pick_global(pick_global), .pred_taken(pred_taken),
    .btb_hit(btb_hit), .next_pc(next_pc), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target)
  );

  int m_bim[64], m_gbl[64], m_cho[64];
  bit m_tv[16];
  int unsigned m_tt[16], m_td[16];
  int m_h = 0;

  function automatic int up_dn(int c, bit up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin m_bim[i] = 1; m_gbl[i] = 1; m_cho[i] = 1; end
    for (int i = 0; i < 16; i++) begin m_tv[i] = 0; m_tt[i] = 0; m_td[i] = 0; end
    m_h = 0;
  endtask

  task automatic check(string req, string ph, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (%s) got=%h expected=%h", req, ph, got, exp);
    end
  endtask

  task automatic compare_all(string ph);
    int unsigned p = fetch_pc;
    int bi = (p >> 2) % 64, ti = (p >> 2) % 16;
    bit eb = m_bim[bi] >= 2, eg = m_gbl[m_h] >= 2, ec = m_cho[bi] >= 2;
    bit ep = ec ? eg : eb;
    bit eh = m_tv[ti] && (m_tt[ti] == (p >> 6));
    check("R2", ph, 32'(bim_taken), 32'(eb));
    check("R3", ph, 32'(gbl_taken), 32'(eg));
    check("R4", ph, 32'(pick_global), 32'(ec));
    check("R4", ph, 32'(pred_taken), 32'(ep));
    check("R7", ph, 32'(btb_hit), 32'(eh));
    check("R8", ph, next_pc, (eh && ep) ? m_td[ti] : p + 4);
  endtask

  task automatic model_update();
    int unsigned p = res_pc;
    int bi = (p >> 2) % 64, ti = (p >> 2) % 16;
    int bc = m_bim[bi], gc = m_gbl[m_h];
    if (!res_valid) return;
    m_bim[bi] = up_dn(bc, res_taken);
    m_gbl[m_h] = up_dn(gc, res_taken);
    if ((bc >= 2) != (gc >= 2)) m_cho[bi] = up_dn(m_cho[bi], (gc >= 2) == res_taken);
    m_h = ((m_h << 1) | int'(res_taken)) % 64;
    if (res_taken) begin m_tv[ti] = 1; m_tt[ti] = p >> 6; m_td[ti] = res_target; end
  endtask

  task automatic step(logic [31:0] fpc, bit rv, logic [31:0] rpc, bit rt, logic [31:0] rtg, string ph);
    @(negedge clk);
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtg;
    #5 compare_all(ph);
    @(posedge clk);
    model_update();
  endtask

  task automatic branch(logic [31:0] pc, bit t, string ph);
    step(pc, 1'b1, pc, t, pc + 32'h400, ph);
  endtask

  localparam logic [31:0] PA = 32'h0000_1000;
  localparam logic [31:0] PB = 32'h0000_1100;
  localparam logic [31:0] PC2 = 32'h0000_2008;

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      fetch_pc = 32'h40 * k + 32'h1004;
      #1;
      check("R1", "reset", 32'(bim_taken | gbl_taken | pick_global | btb_hit), 32'h0);
      check("R1", "reset", next_pc, fetch_pc + 4);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) branch(PA, 1'b1, "R2 saturate high");
    for (int i = 0; i < 5; i++) branch(PB, 1'b0, "R2 saturate low");
    for (int i = 0; i < 6; i++) begin
      step(32'h3000 + 32'(i * 4), 1'b0, $urandom, 1'($urandom), $urandom, "R9 idle");
    end
    for (int i = 0; i < 24; i++) branch(PC2, (i % 4) != 3, "R5 R6 pattern 1110");
    for (int i = 0; i < 16; i++) branch(PA + 32'h100, i[0], "R5 alternate alias");
    step(PA, 1'b0, '0, 1'b0, '0, "R7 tag after alias");
    step(PA + 32'h40, 1'b0, '0, 1'b0, '0, "R7 tag mismatch");
    begin
      bit prev = 0;
      for (int i = 0; i < 3000; i++) begin
        int k = $urandom % 6;
        logic [31:0] pc = 32'h4000 + 32'(k * 36) + ((i % 97 == 0) ? 32'h100 : 32'h0);
        bit t;
        case (k)
          0: t = 1;
          1: t = 0;
          2: t = (i % 4) != 3;
          3: t = i[0];
          4: t = prev;
          default: t = 1'($urandom);
        endcase
        if ($urandom % 5 == 0) step(pc, 1'b0, $urandom, 1'($urandom), $urandom, "R9 mixed idle");
        else begin branch(pc, t, "R6 mixed run"); prev = t; end
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule